// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block sends a stream of stereo audio samples out on one data line. Each sample pair holds a 24-bit left word and a 24-bit right word in two's complement. The bits go out most significant bit first, timed by a bit clock and a frame clock whose level marks the channel in flight. A run-time select picks between two framings: I2S, where the data trails the frame edge by one bit, and left-justified, where the data starts on the frame edge.

The port is either the timing master or the timing slave. As master it divides the system clock down to its own bit and frame clocks. As slave it samples externally driven bit and frame clocks through synchronizers. The role is read from the level on the data pad while reset is held, because the pad doubles as a startup strap. The data driver stays off until reset is released.

Samples arrive as a parallel pair qualified by a valid strobe. The most recent pair is held and copied into the output snapshot when each new left channel begins. If nothing new arrives, the same pair is sent again.

Top module: `stereo_ser_tx`

## Requirements
- R1: Each channel word is sent as 24 bits, most significant first, with the left and right words of one pair sent in consecutive channels, left first.
- R2: With fmt_sel_i = 0 (I2S), the left word is sent while the frame clock is low and the right word while it is high. The most significant bit is sampled on the second rising bit clock edge after a frame clock change.
- R3: With fmt_sel_i = 1 (left-justified), the left word is sent while the frame clock is high and the right word while it is low. The most significant bit is sampled on the first rising bit clock edge after a frame clock change.
- R4: Every bit slot of a channel beyond its 24 data bits carries 0.
- R5: The pair held on the most recent smp_valid_i is copied into the output snapshot when a left channel starts. The left and right words of one frame always come from the same pair. A pair offered after that point, including in the very cycle the left channel starts, goes out in the following frame. With no new pair, the previous pair is repeated.
- R6: sd_o changes only while the bit clock is low, after its falling edge. In master role this is one system clock after the falling edge.
- R7: In master role, bclk_o has a period of 2*MST_HALF system clocks and each frame holds 2*MST_SLOTS bit clocks (32 per channel by default). fclk_o changes only together with a falling edge of bclk_o.
- R8: master_o takes the level of pad_strap_i seen while rst_n is low (1 = master, 0 = slave). Changes on pad_strap_i after reset have no effect.
- R9: In slave role, timing follows bclk_i and fclk_i, with any channel length from 24 to MAX_SLOTS bit clocks. In I2S with exactly 24 bit clocks per channel, the least significant bit of a channel falls in the first slot after the next frame clock change.
- R10: During reset, sd_o and sd_oe_o are 0 and the held pair is cleared. The first channel emitted after reset therefore carries all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid_i | input | 1 | Qualifies a new sample pair |
| smp_left_i | input | 24 | Left sample, two's complement |
| smp_right_i | input | 24 | Right sample, two's complement |
| fmt_sel_i | input | 1 | Framing: 0 I2S, 1 left-justified |
| bclk_i | input | 1 | External bit clock (slave role) |
| fclk_i | input | 1 | External frame clock (slave role) |
| pad_strap_i | input | 1 | Level read back from the data pad (startup strap) |
| master_o | output | 1 | Role latched at reset: 1 master, 0 slave |
| bclk_o | output | 1 | Generated bit clock (master role) |
| fclk_o | output | 1 | Generated frame clock (master role) |
| sd_o | output | 1 | Serial data |
| sd_oe_o | output | 1 | Output enable for the data pad |

## Verification
A new pair can arrive in the same system clock cycle in which the left channel starts and the snapshot is taken. The design must then send the older pair for that whole frame and the new pair in the next one. The bench provokes this in master role by waiting for fclk_o to move to the left level and pulsing smp_valid_i in the cycle right after. It then decodes the serial stream and requires the old pair in both channels of that frame and the new pair in both channels of the frame that follows. A second, milder overlap is also checked: a pair offered mid-left-channel must not tear the current frame.

// File: rtl/stx_pkg.sv
package stx_pkg;
   typedef enum logic {
      FMT_I2S = 1'b0,
      FMT_LJ  = 1'b1
   } stx_fmt_e;

   // frame clock level that marks the left channel for a framing
   function automatic logic left_level(stx_fmt_e f);
      return (f == FMT_LJ);
   endfunction
endpackage

// File: rtl/stx_mst_clkgen.sv
module stx_mst_clkgen
   import stx_pkg::*;
#(
   parameter int HALF  = 4,
   parameter int SLOTS = 32
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en,
   input  stx_fmt_e fmt,
   output logic     bclk,
   output logic     fclk,
   output logic     tick,
   output logic     lvl
);
   localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
   localparam int FW = $clog2(2 * SLOTS);
   localparam logic [HW-1:0] HLAST = HW'(HALF - 1);
   localparam logic [FW-1:0] PLAST = FW'(2 * SLOTS - 1);
   localparam logic [FW-1:0] PHALF = FW'(SLOTS);

   logic [HW-1:0] hcnt;
   logic [FW-1:0] pos;
   logic [FW-1:0] pos_n;
   logic          fr_n;

   always_comb begin
      pos_n = (pos == PLAST) ? '0 : pos + 1'b1;
      // first half of a frame carries the left channel
      fr_n  = (pos_n >= PHALF) ^ left_level(fmt);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         hcnt <= '0;
         bclk <= 1'b1;
         pos  <= PLAST;
         fclk <= 1'b0;
         tick <= 1'b0;
      end else begin
         tick <= 1'b0;
         if (hcnt == HLAST) begin
            hcnt <= '0;
            bclk <= ~bclk;
            if (bclk) begin
               pos  <= pos_n;
               fclk <= fr_n;
               tick <= 1'b1;
            end
         end else begin
            hcnt <= hcnt + 1'b1;
         end
      end
   end

   assign lvl = fclk;

   // R7
   fclk_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
      $changed(fclk) |-> $fell(bclk));
   // R7
   bclk_min_half_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
      $changed(bclk) |=> $stable(bclk));
endmodule

// File: rtl/stx_slv_sync.sv
module stx_slv_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_in,
   input  logic fclk_in,
   output logic tick,
   output logic lvl
);
   logic [STAGES-1:0] b_sr;
   logic [STAGES-1:0] f_sr;
   logic              b_last;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               b_sr <= 1'b1;
               f_sr <= 1'b0;
            end else begin
               b_sr <= bclk_in;
               f_sr <= fclk_in;
            end
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               b_sr <= '1;
               f_sr <= '0;
            end else begin
               b_sr <= {b_sr[STAGES-2:0], bclk_in};
               f_sr <= {f_sr[STAGES-2:0], fclk_in};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) b_last <= 1'b1;
      else        b_last <= b_sr[STAGES-1];
   end

   assign tick = b_last & ~b_sr[STAGES-1];
   assign lvl  = f_sr[STAGES-1];

   // R9
   tick_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
   import stx_pkg::*;
#(
   parameter int W         = 24,
   parameter int MAX_SLOTS = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         lvl,
   input  stx_fmt_e     fmt,
   input  logic [W-1:0] hold_l,
   input  logic [W-1:0] hold_r,
   output logic         sd
);
   localparam int CW = $clog2(MAX_SLOTS + 1);
   localparam logic [CW-1:0] SAT = CW'(MAX_SLOTS);

   logic          have_lv, prev_lv, synced;
   logic [CW-1:0] slot, slot_n;
   logic [W-1:0]  act_l, act_r, cur_w, old_w;
   logic          trans, is_left, start, bit_n, emit;

   function automatic logic pick(logic [W-1:0] w, int k);
      if (k >= 0 && k < W) return w[W-1-k];
      return 1'b0;
   endfunction

   always_comb begin
      trans   = have_lv && (lvl != prev_lv);
      is_left = (lvl == left_level(fmt));
      start   = trans && is_left;
      cur_w   = is_left ? (start ? hold_l : act_l) : act_r;
      old_w   = is_left ? act_r : act_l;
      if (trans)            slot_n = '0;
      else if (slot == SAT) slot_n = slot;
      else                  slot_n = slot + 1'b1;
      if (fmt == FMT_I2S) begin
         // first slot after an edge still belongs to the previous channel
         if (trans) bit_n = pick(old_w, int'(slot));
         else       bit_n = pick(cur_w, int'(slot_n) - 1);
      end else begin
         bit_n = pick(cur_w, int'(slot_n));
      end
      emit = synced || (trans && fmt == FMT_LJ);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_lv <= 1'b0;
         prev_lv <= 1'b0;
         synced  <= 1'b0;
         slot    <= '0;
         act_l   <= '0;
         act_r   <= '0;
         sd      <= 1'b0;
      end else if (tick) begin
         have_lv <= 1'b1;
         prev_lv <= lvl;
         slot    <= slot_n;
         if (trans) synced <= 1'b1;
         if (start) begin
            act_l <= hold_l;
            act_r <= hold_r;
         end
         sd <= emit & bit_n;
      end
   end

   // R6
   sd_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(sd) |-> $past(tick));
   // R4
   pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && synced && !trans && slot >= CW'(W)) |=> !sd);
endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx
   import stx_pkg::*;
#(
   parameter int SAMPLE_W    = 24,
   parameter int MST_SLOTS   = 32,
   parameter int MST_HALF    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int MAX_SLOTS   = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_valid_i,
   input  logic [SAMPLE_W-1:0] smp_left_i,
   input  logic [SAMPLE_W-1:0] smp_right_i,
   input  logic                fmt_sel_i,
   input  logic                bclk_i,
   input  logic                fclk_i,
   input  logic                pad_strap_i,
   output logic                master_o,
   output logic                bclk_o,
   output logic                fclk_o,
   output logic                sd_o,
   output logic                sd_oe_o
);
   generate
      if (SAMPLE_W < 1 || MST_SLOTS < SAMPLE_W || MAX_SLOTS < MST_SLOTS)
      begin : g_bad_width
         $error("stereo_ser_tx: slot counts must cover the sample width");
      end
      if (MST_HALF < 2) begin : g_bad_half
         $error("stereo_ser_tx: MST_HALF must be at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("stereo_ser_tx: SYNC_STAGES must be at least 1");
      end
   endgenerate

   stx_fmt_e            fmt;
   logic [SAMPLE_W-1:0] hold_l, hold_r;
   logic                m_tick, m_lvl, s_tick, s_lvl, tick, lvl;

   assign fmt = stx_fmt_e'(fmt_sel_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         master_o <= pad_strap_i;
         sd_oe_o  <= 1'b0;
         hold_l   <= '0;
         hold_r   <= '0;
      end else begin
         sd_oe_o <= 1'b1;
         if (smp_valid_i) begin
            hold_l <= smp_left_i;
            hold_r <= smp_right_i;
         end
      end
   end

   stx_mst_clkgen #(.HALF(MST_HALF), .SLOTS(MST_SLOTS)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .en(master_o), .fmt(fmt),
      .bclk(bclk_o), .fclk(fclk_o), .tick(m_tick), .lvl(m_lvl));

   stx_slv_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .bclk_in(bclk_i), .fclk_in(fclk_i),
      .tick(s_tick), .lvl(s_lvl));

   assign tick = master_o ? m_tick : s_tick;
   assign lvl  = master_o ? m_lvl  : s_lvl;

   stx_shifter #(.W(SAMPLE_W), .MAX_SLOTS(MAX_SLOTS)) u_shift (
      .clk(clk), .rst_n(rst_n), .tick(tick), .lvl(lvl), .fmt(fmt),
      .hold_l(hold_l), .hold_r(hold_r), .sd(sd_o));

   // R8
   role_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(master_o));
   // R10
   oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> sd_oe_o);
endmodule

// File: tb/stereo_ser_tx_tb.sv
`timescale 1ns/1ps
module stereo_ser_tx_tb;
   localparam int HALF = 4;
   localparam int SH   = 8;

   // [55:50] slave slots, [49] master, [48] fmt, [47:24] left, [23:0] right
   localparam int NV = 6;
   localparam logic [55:0] VEC [0:NV-1] = '{
      {6'd32, 1'b1, 1'b0, 24'h800001, 24'h7FFFFE},
      {6'd32, 1'b1, 1'b1, 24'hA5A5A5, 24'h5A5A5A},
      {6'd32, 1'b0, 1'b0, 24'h123456, 24'hFEDCBA},
      {6'd32, 1'b0, 1'b1, 24'h000001, 24'h800000},
      {6'd24, 1'b0, 1'b0, 24'hC00003, 24'h3FFFFC},
      {6'd24, 1'b0, 1'b1, 24'hF0F0F1, 24'h0F0F0E}
   };

   logic clk = 0, rst_n = 0, valid = 0, fmt = 0, s_bclk = 1, s_fclk = 0, strap = 1;
   logic [23:0] left = 0, right = 0;
   logic master_o, bclk_o, fclk_o, sd_o, sd_oe_o;
   logic tb_master = 1;
   int tests = 0, fails = 0, viol = 0;

   always #2 clk = ~clk;

   stereo_ser_tx u_dut (
      .clk(clk), .rst_n(rst_n), .smp_valid_i(valid), .smp_left_i(left),
      .smp_right_i(right), .fmt_sel_i(fmt), .bclk_i(s_bclk), .fclk_i(s_fclk),
      .pad_strap_i(strap), .master_o(master_o), .bclk_o(bclk_o),
      .fclk_o(fclk_o), .sd_o(sd_o), .sd_oe_o(sd_oe_o));

   wire cap_bclk = tb_master ? bclk_o : s_bclk;
   wire cap_fclk = tb_master ? fclk_o : s_fclk;

   // capture of decoded channels
   logic cap_en = 0, have_lv = 0, cur_lv = 0;
   logic bits [0:63];
   int nb = 0, cap_n = 0;
   logic [23:0] cw [0:23];
   logic cl [0:23], cp [0:23];
   int cs [0:23];

   task put(input logic b);
      if (nb < 64) bits[nb] = b;
      nb++;
   endtask

   task finish_chan();
      logic [23:0] w;
      logic pad;
      w = '0; pad = 1'b1;
      for (int k = 0; k < nb && k < 64; k++) begin
         if (k < 24) w[23-k] = bits[k];
         else if (bits[k]) pad = 1'b0;
      end
      if (cap_n < 24) begin
         cw[cap_n] = w; cl[cap_n] = (cur_lv == fmt);
         cs[cap_n] = nb; cp[cap_n] = pad;
      end
      cap_n++;
   endtask

   task do_sample(input logic b, input logic lv);
      if (!have_lv) begin
         have_lv = 1; cur_lv = lv; nb = 0;
      end
      if (lv != cur_lv) begin
         if (fmt == 1'b0) put(b);
         finish_chan();
         nb = 0; cur_lv = lv;
         if (fmt == 1'b1) put(b);
      end else begin
         put(b);
      end
   endtask

   task clear_cap();
      cap_n = 0; have_lv = 0; nb = 0;
   endtask

   initial forever begin
      @(posedge cap_bclk);
      #1;
      if (cap_en) do_sample(sd_o, cap_fclk);
   end

   // R6 monitor: data must not move while the bit clock is high
   always @(sd_o) if (cap_en && cap_bclk === 1'b1) viol++;

   task chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task wait_cap(input int n);
      while (cap_n < n) @(negedge clk);
   endtask

   task do_reset(input logic m, input logic f);
      cap_en = 0;
      @(negedge clk);
      rst_n = 0; strap = m; fmt = f; tb_master = m; s_bclk = 1; s_fclk = ~f;
      repeat (5) @(negedge clk);
      chk(sd_oe_o == 1'b0, "R10 oe in reset", {31'd0, sd_oe_o}, 0);
      chk(sd_o == 1'b0, "R10 data in reset", {31'd0, sd_o}, 0);
      rst_n = 1;
      clear_cap();
      cap_en = 1;
      @(negedge clk);
      chk(master_o == m, "R8 role strap", {31'd0, master_o}, {31'd0, m});
   endtask

   task offer(input logic [23:0] l, input logic [23:0] r);
      left = l; right = r; valid = 1;
      @(negedge clk);
      valid = 0;
   endtask

   task slave_run(input int frames, input int slots, input logic f);
      for (int fr = 0; fr <= frames; fr++) begin
         for (int ch = 0; ch < 2; ch++) begin
            for (int s = 0; s < slots; s++) begin
               if (fr == frames && (ch == 1 || s > 2)) break;
               s_bclk = 0;
               if (s == 0) s_fclk = (ch == 0) ? f : ~f;
               repeat (SH) @(negedge clk);
               s_bclk = 1;
               repeat (SH) @(negedge clk);
            end
         end
      end
   endtask

   task expect_pair(input int i, input logic [23:0] l, input logic [23:0] r, input string tag);
      chk(cl[i] == 1'b1 && cw[i] == l, {tag, " left word"}, {8'd0, cw[i]}, {8'd0, l});
      chk(cl[i+1] == 1'b0 && cw[i+1] == r, {tag, " right word"}, {8'd0, cw[i+1]}, {8'd0, r});
   endtask

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      realtime t0, t1;
      int il;
      // vector table walk: R1 R2 R3 R4 R7 R9 R10
      for (int i = 0; i < NV; i++) begin
         do_reset(VEC[i][49], VEC[i][48]);
         offer(VEC[i][47:24], VEC[i][23:0]);
         if (VEC[i][49]) wait_cap(4);
         else slave_run(3, int'(VEC[i][55:50]), VEC[i][48]);
         chk(cw[1] == 24'h0, "R10 first channel zero", {8'd0, cw[1]}, 0);
         expect_pair(2, VEC[i][47:24], VEC[i][23:0], VEC[i][48] ? "R1 R3" : "R1 R2");
         chk(cp[2] && cp[3], "R4 pad slots zero", {30'd0, cp[2], cp[3]}, 3);
         chk(cs[2] == int'(VEC[i][55:50]) && cs[3] == int'(VEC[i][55:50]),
             VEC[i][49] ? "R7 slots per channel" : "R9 slave slots",
             cs[2], {26'd0, VEC[i][55:50]});
         if (i == 0) begin
            @(posedge bclk_o); t0 = $realtime;
            @(posedge bclk_o); t1 = $realtime;
            chk((t1 - t0) == 2 * HALF * 4, "R7 bit clock period",
                int'(t1 - t0), 2 * HALF * 4);
            strap = 0;
            repeat (20) @(negedge clk);
            chk(master_o == 1'b1, "R8 strap ignored after reset", {31'd0, master_o}, 1);
         end
      end

      // R5 pairing, repeat, and valid in the snapshot cycle (master, I2S)
      do_reset(1'b1, 1'b0);
      offer(24'h111111, 24'h222222);
      wait_cap(3);
      offer(24'h333333, 24'h444444);
      wait_cap(8);
      expect_pair(4, 24'h333333, 24'h444444, "R5 new pair next frame");
      expect_pair(6, 24'h333333, 24'h444444, "R5 repeat without valid");
      offer(24'h555555, 24'h666666);
      wait_cap(11);
      chk(cw[9] == 24'h444444, "R5 frame not torn", {8'd0, cw[9]}, 32'h444444);
      chk(cw[10] == 24'h555555, "R5 mid-frame pair next", {8'd0, cw[10]}, 32'h555555);
      do @(fclk_o); while (fclk_o != 1'b0);
      @(negedge clk);
      il = cap_n + 1;
      offer(24'h777777, 24'h888888);
      wait_cap(il + 4);
      expect_pair(il, 24'h555555, 24'h666666, "R5 same-cycle old pair");
      expect_pair(il + 2, 24'h777777, 24'h888888, "R5 same-cycle new pair");

      chk(viol == 0, "R6 data stable while bit clock high", viol, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule